// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column burst request into the stream of column addresses that a memory controller places on the bus, one address per accepted beat. A request carries a starting column, a 3-bit burst-length code and an ordering bit. Every beat of a fixed-length burst stays inside the aligned group of columns whose size equals the burst length. The ordering bit selects whether beats step upward and wrap inside that group, or visit it in XOR order. A full-page burst steps upward through the whole page, wraps from the top column back to column zero, and keeps going until the terminate input is raised.

Requests enter on a valid/ready pair. `cmd_ready` is high whenever no burst is in progress, so a request waits until the current burst has finished. Beats leave on a second valid/ready pair. While `beat_valid` is high and `beat_ready` is low, the beat is held: the address does not change and the burst does not advance. A request with an illegal code is consumed without producing any beat, and a one-cycle error pulse reports it.

Top module: `burst_colgen`

## Requirements
- R1: After reset, and after reset is asserted during a burst, `beat_valid` is low, `err` is low and `cmd_ready` is high.
- R2: A request is taken in a cycle where `cmd_valid` and `cmd_ready` are both high. For a legal request, `beat_valid` rises on the next cycle with beat 0, and `cmd_ready` stays low until the last beat has been accepted.
- R3: In a fixed burst of length BL, column bits at position log2(BL) and above equal those of the start column on every beat.
- R4: With `cmd_order`=0 (sequential), the low log2(BL) bits of beat n are (start + n) mod BL.
- R5: With `cmd_order`=1 (interleaved), the low log2(BL) bits of beat n are start XOR n.
- R6: `cmd_bl` codes are 000=1, 001=2, 010=4, 011=8 and 111=full page. A fixed burst gives exactly BL beats. `beat_last` is high on the final beat only, and `beat_valid` falls after that beat is accepted.
- R7: While `beat_valid` is high and `beat_ready` is low, `beat_col` holds its value and the burst does not advance.
- R8: In a full-page burst, beat n has column (start + n) mod 2^COL_W, so the column wraps from the top of the page to 0.
- R9: In a full-page burst, `beat_last` follows `term` while a beat is valid, and the burst ends when that beat is accepted. During a fixed burst, `term` has no effect.
- R10: A request with code 100, 101 or 110, or with code 111 and `cmd_order`=1, produces no beats. It raises `err` for exactly the next cycle and leaves `cmd_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Burst request present |
| cmd_ready | output | 1 | Block idle, request will be taken |
| cmd_start | input | COL_W | Starting column |
| cmd_bl | input | 3 | Burst length code |
| cmd_order | input | 1 | 0 sequential, 1 interleaved |
| beat_valid | output | 1 | Beat address present |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_col | output | COL_W | Column address of current beat |
| beat_last | output | 1 | Current beat ends the burst |
| term | input | 1 | Ends a full-page burst on the current beat |
| err | output | 1 | One-cycle pulse for an illegal request |

## Verification
Beat 0 and `err` appear one clock after the edge that takes the request. Each later beat appears one clock after the edge where `beat_valid` and `beat_ready` were both high. `beat_last` follows `term` combinationally during a full-page burst. The bench drives inputs on falling edges and checks on the following falling edge, so every registered result has exactly one rising edge to settle. `beat_last` is checked 1 time unit after `term` is driven in the same half cycle. Stall checks hold `beat_ready` low over one rising edge and compare the address across it.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  typedef enum logic [2:0] {
    BLC_1    = 3'b000,
    BLC_2    = 3'b001,
    BLC_4    = 3'b010,
    BLC_8    = 3'b011,
    BLC_PAGE = 3'b111
  } bl_code_e;

  typedef enum logic {
    ORD_SEQ   = 1'b0,
    ORD_INTLV = 1'b1
  } order_e;
endpackage

// File: rtl/colgen_decode.sv
module colgen_decode
  import colgen_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [2:0]       code,
  input  logic             order,
  output logic             legal,
  output logic             full,
  output logic [COL_W-1:0] mask
);
  always_comb begin
    legal = 1'b1;
    full  = 1'b0;
    mask  = '0;
    case (code)
      BLC_1:    mask = '0;
      BLC_2:    mask = COL_W'(1);
      BLC_4:    mask = COL_W'(3);
      BLC_8:    mask = COL_W'(7);
      BLC_PAGE: begin
        mask = '1;
        full = 1'b1;
      end
      default:  legal = 1'b0;
    endcase
    if (full && order == ORD_INTLV) legal = 1'b0;
  end
endmodule

// File: rtl/colgen_addr.sv
module colgen_addr
  import colgen_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] start,
  input  logic [COL_W-1:0] mask,
  input  logic [COL_W-1:0] cnt,
  input  logic             order,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] lo;
  logic [COL_W-1:0] off;

  always_comb begin
    lo  = start & mask;
    off = (order == ORD_INTLV) ? (lo ^ cnt) : (lo + cnt);
    col = (start & ~mask) | (off & mask);
  end
endmodule

// File: rtl/colgen_ctrl.sv
module colgen_ctrl #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             legal,
  input  logic             full_in,
  input  logic [COL_W-1:0] mask_in,
  input  logic [COL_W-1:0] start_in,
  input  logic             order_in,
  input  logic             beat_ready,
  input  logic             term,
  output logic             busy,
  output logic [COL_W-1:0] cnt,
  output logic [COL_W-1:0] start_q,
  output logic [COL_W-1:0] mask_q,
  output logic             full_q,
  output logic             order_q,
  output logic             last,
  output logic             err
);
  assign last = busy && (full_q ? term : (cnt == mask_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      start_q <= '0;
      mask_q  <= '0;
      full_q  <= 1'b0;
      order_q <= 1'b0;
      err     <= 1'b0;
    end else begin
      err <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          if (legal) begin
            busy    <= 1'b1;
            cnt     <= '0;
            start_q <= start_in;
            mask_q  <= mask_in;
            full_q  <= full_in;
            order_q <= order_in;
          end else begin
            err <= 1'b1;
          end
        end
      end else if (beat_ready) begin
        if (last) busy <= 1'b0;
        else      cnt  <= cnt + 1'b1;
      end
    end
  end

  // R10
  bad_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && !legal) |=> (err && !busy));

  // R2
  take_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && legal) |=> (busy && cnt == '0));
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [COL_W-1:0] cmd_start,
  input  logic [2:0]       cmd_bl,
  input  logic             cmd_order,
  output logic             beat_valid,
  input  logic             beat_ready,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last,
  input  logic             term,
  output logic             err
);
  logic             dec_legal, dec_full;
  logic [COL_W-1:0] dec_mask;
  logic             busy, full_q, order_q;
  logic [COL_W-1:0] cnt, start_q, mask_q;

  colgen_decode #(.COL_W(COL_W)) u_dec (
    .code(cmd_bl), .order(cmd_order),
    .legal(dec_legal), .full(dec_full), .mask(dec_mask)
  );

  colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .legal(dec_legal), .full_in(dec_full), .mask_in(dec_mask),
    .start_in(cmd_start), .order_in(cmd_order),
    .beat_ready(beat_ready), .term(term),
    .busy(busy), .cnt(cnt), .start_q(start_q), .mask_q(mask_q),
    .full_q(full_q), .order_q(order_q), .last(beat_last), .err(err)
  );

  colgen_addr #(.COL_W(COL_W)) u_addr (
    .start(start_q), .mask(mask_q), .cnt(cnt), .order(order_q),
    .col(beat_col)
  );

  assign beat_valid = busy;
  assign cmd_ready  = !busy;

  // R3
  block_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !full_q) |-> (((beat_col ^ start_q) & ~mask_q) == '0));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_col)));

  // R4
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && !beat_last && order_q == ORD_SEQ)
      |=> ((beat_col & mask_q) == (($past(beat_col) + 1'b1) & mask_q)));

  // R9
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && beat_last) |=> !beat_valid);
endmodule

// File: tb/sim_burst_colgen.sv
module sim_burst_colgen;
  localparam int CLK_P = 10;
  localparam int COL_W = 10;

  typedef struct packed {
    logic [2:0]  code;
    logic        ord;
    logic [9:0]  start;
    logic [31:0] nbeats;
    logic        stall;
    logic        hold_term;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{3'b000, 1'b0, 10'h155, 32'd1, 1'b0, 1'b0},
    '{3'b001, 1'b0, 10'h0A3, 32'd2, 1'b0, 1'b0},
    '{3'b010, 1'b0, 10'h016, 32'd4, 1'b1, 1'b0},
    '{3'b011, 1'b0, 10'h3FD, 32'd8, 1'b0, 1'b1},
    '{3'b001, 1'b1, 10'h201, 32'd2, 1'b0, 1'b0},
    '{3'b010, 1'b1, 10'h0C6, 32'd4, 1'b0, 1'b1},
    '{3'b011, 1'b1, 10'h12B, 32'd8, 1'b1, 1'b0},
    '{3'b011, 1'b0, 10'h000, 32'd8, 1'b0, 1'b0},
    '{3'b000, 1'b1, 10'h2AA, 32'd1, 1'b0, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0, cmd_order = 1'b0;
  logic [COL_W-1:0] cmd_start = '0;
  logic [2:0]       cmd_bl = '0;
  logic             beat_ready = 1'b0, term = 1'b0;
  logic             cmd_ready, beat_valid, beat_last, err;
  logic [COL_W-1:0] beat_col;
  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  burst_colgen #(.COL_W(COL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_start(cmd_start), .cmd_bl(cmd_bl), .cmd_order(cmd_order),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_col(beat_col),
    .beat_last(beat_last), .term(term), .err(err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_col(input logic [2:0] code, input logic ord,
                                         input logic [9:0] st, input int n);
    int bl, base, lo, off;
    if (code == 3'b111) return 10'((st + n) % 1024);
    bl   = 1 << code;
    base = st - (st % bl);
    lo   = st % bl;
    off  = ord ? (lo ^ n) : ((lo + n) % bl);
    return 10'(base + off);
  endfunction

  task automatic run_burst(input logic [2:0] code, input logic ord, input logic [9:0] st,
                           input int nb, input logic stall, input logic hold_term, input string tag);
    logic [9:0] held;
    bit full;
    full = (code == 3'b111);
    @(negedge clk);
    chk(cmd_ready == 1'b1, {tag, " R2 idle ready"}, 32'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_bl = code; cmd_order = ord; cmd_start = st;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(beat_valid == 1'b1, {tag, " R2 first beat"}, 32'(beat_valid), 1);
    chk(cmd_ready == 1'b0, {tag, " R2 busy"}, 32'(cmd_ready), 0);
    for (int n = 0; n < nb; n++) begin
      term = full ? (n == nb - 1) : hold_term;
      #1;
      chk(beat_col == exp_col(code, ord, st, n), {tag, " R3 R4 R5 R8 col"},
          32'(beat_col), 32'(exp_col(code, ord, st, n)));
      chk(beat_last == (n == nb - 1), {tag, " R6 R9 last"}, 32'(beat_last), 32'(n == nb - 1));
      if (stall && n == 1) begin
        held = beat_col;
        beat_ready = 1'b0;
        @(negedge clk);
        #1;
        chk(beat_valid && beat_col == held, {tag, " R7 hold"}, 32'(beat_col), 32'(held));
      end
      beat_ready = 1'b1;
      @(negedge clk);
      beat_ready = 1'b0;
      term = 1'b0;
    end
    chk(beat_valid == 1'b0, {tag, " R6 R9 ended"}, 32'(beat_valid), 0);
    chk(cmd_ready == 1'b1, {tag, " R2 ready again"}, 32'(cmd_ready), 1);
  endtask

  task automatic run_bad(input logic [2:0] code, input logic ord);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_bl = code; cmd_order = ord; cmd_start = 10'h044;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(err == 1'b1, "R10 err pulse", 32'(err), 1);
    chk(beat_valid == 1'b0, "R10 no beat", 32'(beat_valid), 0);
    chk(cmd_ready == 1'b1, "R10 still ready", 32'(cmd_ready), 1);
    @(negedge clk);
    chk(err == 1'b0 && beat_valid == 1'b0, "R10 err one cycle", 32'({err, beat_valid}), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(beat_valid == 1'b0, "R1 valid low", 32'(beat_valid), 0);
    chk(cmd_ready == 1'b1, "R1 ready high", 32'(cmd_ready), 1);
    chk(err == 1'b0, "R1 err low", 32'(err), 0);

    foreach (VECS[i])
      run_burst(VECS[i].code, VECS[i].ord, VECS[i].start, int'(VECS[i].nbeats),
                VECS[i].stall, VECS[i].hold_term, "vec");

    // R8 R9 full page wrap, short and long
    run_burst(3'b111, 1'b0, 10'd1020, 8, 1'b0, 1'b0, "page wrap");
    run_burst(3'b111, 1'b0, 10'd5, 1030, 1'b1, 1'b0, "page long");
    run_burst(3'b111, 1'b0, 10'h3FF, 1, 1'b0, 1'b0, "page one");

    // R10 illegal requests
    run_bad(3'b100, 1'b0);
    run_bad(3'b101, 1'b1);
    run_bad(3'b110, 1'b0);
    run_bad(3'b111, 1'b1);

    // R1 reset during a burst
    @(negedge clk);
    cmd_valid = 1'b1; cmd_bl = 3'b011; cmd_order = 1'b0; cmd_start = 10'h010;
    @(negedge clk);
    cmd_valid = 1'b0; beat_ready = 1'b1;
    @(negedge clk);
    rst_n = 1'b0; beat_ready = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(beat_valid == 1'b0, "R1 mid-burst reset valid", 32'(beat_valid), 0);
    chk(cmd_ready == 1'b1, "R1 mid-burst reset ready", 32'(cmd_ready), 1);
    run_burst(3'b010, 1'b0, 10'h1F3, 4, 1'b0, 1'b0, "after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule